// File: doc/BRIEF.md
# Integer Exception Status Register

This block holds the 32-bit integer exception status word of an integer pipeline. It keeps three arithmetic flags: a sticky summary overflow, a per-operation overflow and a carry. It also keeps a 7-bit transfer byte count, which sets the length of indexed string loads and stores. The execution unit updates the flags after each overflow-enabled or carry-producing operation. The leftmost-zero-byte detection operation deposits a new byte count. Software can read the whole word at any time, or overwrite it, with no privilege check.

A move-to-condition request copies the three flags into a 4-bit condition field and clears them on the same clock edge. Every output comes straight from a flop, so each result is visible one clock edge after the inputs that cause it.

Top module: `xsr_status_reg`

## Requirements
- R1: Word layout with bit 31 as the most significant bit: SO is bit 31, OV is bit 30, CA is bit 29, the byte count occupies bits 6:0, and bits 28:7 always read as zero.
- R2: SO is sticky. No execution-unit update ever clears it; only a software write or a move-to-condition request can.
- R3: Each overflow-enabled update (`ov_upd_vld`) loads OV with `ov_upd_val`, whether that value is 0 or 1.
- R4: Each carry update (`ca_upd_vld`) loads CA with `ca_upd_val`, whether that value is 0 or 1.
- R5: An overflow-enabled update carrying 1 sets OV and SO on the same edge, so the next read shows both bits as 1.
- R6: A move-to-condition request (`mvcr_req`) clears SO, OV and CA and leaves the byte count unchanged.
- R7: On a move-to-condition request, `cond_field` takes the flag values from before the clear, packed as {SO, OV, CA, 0}, and is visible after the same edge. It then holds until the next request.
- R8: The byte count changes only on a byte-count write (`cnt_wr_vld`) or a software write. `tbc` always equals bits 6:0 of `rd_data`.
- R9: A software write (`sw_wr_en`) loads SO, OV, CA and the byte count from `sw_wr_data`. It overrides any execution-unit update, byte-count write or move-to-condition clear in the same cycle. Data on reserved bits is ignored.
- R10: When a move-to-condition request and execution-unit updates arrive in the same cycle and there is no software write, the flags end up cleared.
- R11: A synchronous, active-high reset clears the whole word and `cond_field` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ov_upd_vld | input | 1 | Overflow-enabled result valid |
| ov_upd_val | input | 1 | Overflow result of that operation |
| ca_upd_vld | input | 1 | Carry-producing result valid |
| ca_upd_val | input | 1 | Carry result of that operation |
| cnt_wr_vld | input | 1 | Byte-count write from zero-byte detection |
| cnt_wr_val | input | 7 | New byte count |
| sw_wr_en | input | 1 | Full-word software write |
| sw_wr_data | input | 32 | Software write data |
| mvcr_req | input | 1 | Move flags to condition field and clear them |
| rd_data | output | 32 | Current status word |
| tbc | output | 7 | Current transfer byte count |
| cond_field | output | 4 | Captured {SO, OV, CA, 0} from the latest move request |

## Verification
Every result is due exactly one rising edge after the cycle that presents its stimulus. This holds for `rd_data`, `tbc` and `cond_field` alike, because each comes straight from a flop with no further stage. The bench drives inputs on the falling edge and advances its reference model for that same rising edge. It compares all three outputs at the next falling edge, so each check lands in the cycle its result first appears. Same-cycle collisions are the main corner cases: a software write against every update, a move request against updates, and an overflow update carrying 0 while SO is set. These are driven directly, and then again in large numbers by the random phase.

// File: rtl/xsr_pkg.sv
package xsr_pkg;
  parameter int XSR_W   = 32;
  parameter int XSR_CNT = 7;

  localparam int SO_POS = XSR_W - 1;
  localparam int OV_POS = XSR_W - 2;
  localparam int CA_POS = XSR_W - 3;
  localparam int RSV_HI = XSR_W - 4;
  localparam int RSV_LO = XSR_CNT;
  localparam int COND_W = 4;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } xsr_flags_t;
endpackage

// File: rtl/xsr_flag_unit.sv
module xsr_flag_unit
  import xsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ov_upd_vld,
  input  logic       ov_upd_val,
  input  logic       ca_upd_vld,
  input  logic       ca_upd_val,
  input  logic       sw_wr_en,
  input  xsr_flags_t sw_flags,
  input  logic       mvcr_req,
  output xsr_flags_t flags_q
);
  xsr_flags_t flags_d;

  // Priority: software write, then move-to-condition clear, then exec updates.
  always_comb begin
    flags_d = flags_q;
    if (sw_wr_en) begin
      flags_d = sw_flags;
    end else if (mvcr_req) begin
      flags_d = '0;
    end else begin
      if (ov_upd_vld) begin
        flags_d.ov = ov_upd_val;
        flags_d.so = flags_q.so | ov_upd_val;
      end
      if (ca_upd_vld) begin
        flags_d.ca = ca_upd_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  // R2: with no software write and no move request, a set SO stays set
  a_r2_so_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags_q.so && !sw_wr_en && !mvcr_req) |=> flags_q.so);

  // R3: an overflow update alone lands its value in OV
  a_r3_ov_load: assert property (@(posedge clk) disable iff (rst)
    (ov_upd_vld && !sw_wr_en && !mvcr_req) |=> (flags_q.ov == $past(ov_upd_val)));

  // R4: a carry update alone lands its value in CA
  a_r4_ca_load: assert property (@(posedge clk) disable iff (rst)
    (ca_upd_vld && !sw_wr_en && !mvcr_req) |=> (flags_q.ca == $past(ca_upd_val)));

  // R10: a move request beats exec updates
  a_r10_mv_over_exec: assert property (@(posedge clk) disable iff (rst)
    (mvcr_req && !sw_wr_en) |=> (flags_q == '0));
endmodule

// File: rtl/xsr_count_unit.sv
module xsr_count_unit #(
  parameter int CNT_W = xsr_pkg::XSR_CNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr_vld,
  input  logic [CNT_W-1:0] cnt_wr_val,
  input  logic             sw_wr_en,
  input  logic [CNT_W-1:0] sw_cnt,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (sw_wr_en)   cnt_q <= sw_cnt;
    else if (cnt_wr_vld) cnt_q <= cnt_wr_val;
  end

  // R8: the count only moves on one of its two write sources
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr_en && !cnt_wr_vld) |=> $stable(cnt_q));
endmodule

// File: rtl/xsr_cond_unit.sv
module xsr_cond_unit
  import xsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mvcr_req,
  input  xsr_flags_t        flags_q,
  output logic [COND_W-1:0] cond_q
);
  always_ff @(posedge clk) begin
    if (rst)           cond_q <= '0;
    else if (mvcr_req) cond_q <= {flags_q.so, flags_q.ov, flags_q.ca, 1'b0};
  end

  // R7: captured value is the pre-clear flags
  a_r7_cond_capture: assert property (@(posedge clk) disable iff (rst)
    mvcr_req |=> (cond_q[3:1] == $past(flags_q)) && !cond_q[0]);

  // R7: field holds between requests
  a_r7_cond_hold: assert property (@(posedge clk) disable iff (rst)
    !mvcr_req |=> $stable(cond_q));
endmodule

// File: rtl/xsr_status_reg.sv
module xsr_status_reg
  import xsr_pkg::*;
#(
  parameter int DATA_W = XSR_W,
  parameter int CNT_W  = XSR_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ov_upd_vld,
  input  logic              ov_upd_val,
  input  logic              ca_upd_vld,
  input  logic              ca_upd_val,
  input  logic              cnt_wr_vld,
  input  logic [CNT_W-1:0]  cnt_wr_val,
  input  logic              sw_wr_en,
  input  logic [DATA_W-1:0] sw_wr_data,
  input  logic              mvcr_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  tbc,
  output logic [3:0]        cond_field
);
  localparam int P_SO  = DATA_W - 1;
  localparam int P_OV  = DATA_W - 2;
  localparam int P_CA  = DATA_W - 3;
  localparam int P_RHI = DATA_W - 4;

  xsr_flags_t       sw_flags;
  xsr_flags_t       flags_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_rsvd_unused;

  assign sw_flags       = '{so: sw_wr_data[P_SO], ov: sw_wr_data[P_OV], ca: sw_wr_data[P_CA]};
  assign wr_rsvd_unused = ^sw_wr_data[P_RHI:CNT_W];

  xsr_flag_unit u_flags (
    .clk        (clk),
    .rst        (rst),
    .ov_upd_vld (ov_upd_vld),
    .ov_upd_val (ov_upd_val),
    .ca_upd_vld (ca_upd_vld),
    .ca_upd_val (ca_upd_val),
    .sw_wr_en   (sw_wr_en),
    .sw_flags   (sw_flags),
    .mvcr_req   (mvcr_req),
    .flags_q    (flags_q)
  );

  xsr_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .cnt_wr_vld (cnt_wr_vld),
    .cnt_wr_val (cnt_wr_val),
    .sw_wr_en   (sw_wr_en),
    .sw_cnt     (sw_wr_data[CNT_W-1:0]),
    .cnt_q      (cnt_q)
  );

  xsr_cond_unit u_cond (
    .clk      (clk),
    .rst      (rst),
    .mvcr_req (mvcr_req),
    .flags_q  (flags_q),
    .cond_q   (cond_field)
  );

  // Assemble the read word; reserved bits tie to zero bit by bit.
  generate
    for (genvar b = CNT_W; b <= P_RHI; b++) begin : g_rsvd
      assign rd_data[b] = 1'b0;
    end
  endgenerate
  assign rd_data[P_SO]      = flags_q.so;
  assign rd_data[P_OV]      = flags_q.ov;
  assign rd_data[P_CA]      = flags_q.ca;
  assign rd_data[CNT_W-1:0] = cnt_q;
  assign tbc                = cnt_q;

  // R1: reserved field reads zero
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[P_RHI:CNT_W] == '0);

  // R5: an overflow of 1 sets both OV and SO on the next read
  a_r5_ov_sets_so: assert property (@(posedge clk) disable iff (rst)
    (ov_upd_vld && ov_upd_val && !sw_wr_en && !mvcr_req) |=> (rd_data[P_SO] && rd_data[P_OV]));

  // R6: move request clears the flags but keeps the count
  a_r6_mv_keeps_cnt: assert property (@(posedge clk) disable iff (rst)
    (mvcr_req && !sw_wr_en && !cnt_wr_vld) |=> ($stable(tbc) && rd_data[P_SO:P_CA] == 3'b000));

  // R9: a software write wins every field
  a_r9_sw_wins: assert property (@(posedge clk) disable iff (rst)
    sw_wr_en |=> (rd_data[P_SO:P_CA] == $past(sw_wr_data[P_SO:P_CA]))
              && (tbc == $past(sw_wr_data[CNT_W-1:0])));

  // R11: reset leaves everything at zero
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && cond_field == '0));
endmodule

// File: tb/xsr_status_reg_tb.sv
`timescale 1ns/1ps
module xsr_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        ov_upd_vld, ov_upd_val, ca_upd_vld, ca_upd_val;
  logic        cnt_wr_vld;
  logic [6:0]  cnt_wr_val;
  logic        sw_wr_en;
  logic [31:0] sw_wr_data;
  logic        mvcr_req;
  logic [31:0] rd_data;
  logic [6:0]  tbc;
  logic [3:0]  cond_field;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit       m_so, m_ov, m_ca;
  bit [6:0] m_tbc;
  bit [3:0] m_cond;

  always #2.5 clk = ~clk;

  xsr_status_reg u_dut (
    .clk(clk), .rst(rst),
    .ov_upd_vld(ov_upd_vld), .ov_upd_val(ov_upd_val),
    .ca_upd_vld(ca_upd_vld), .ca_upd_val(ca_upd_val),
    .cnt_wr_vld(cnt_wr_vld), .cnt_wr_val(cnt_wr_val),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .mvcr_req(mvcr_req),
    .rd_data(rd_data), .tbc(tbc), .cond_field(cond_field)
  );

  function automatic bit [31:0] exp_word();
    return {m_so, m_ov, m_ca, 22'd0, m_tbc};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (rd_data !== exp_word()) begin
      fails++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_word());
    end
    checks++;
    if (tbc !== m_tbc) begin
      fails++;
      $display("FAIL %s tbc actual=%h expected=%h", tag, tbc, m_tbc);
    end
    checks++;
    if (cond_field !== m_cond) begin
      fails++;
      $display("FAIL %s cond_field actual=%h expected=%h", tag, cond_field, m_cond);
    end
  endtask

  // Drive one cycle (called at a falling edge), advance model, check at next falling edge.
  task automatic cycle(input bit ovv, input bit ovd, input bit cav, input bit cad,
                       input bit cwv, input bit [6:0] cwd,
                       input bit sw, input bit [31:0] swd, input bit mv,
                       input string tag);
    ov_upd_vld = ovv; ov_upd_val = ovd; ca_upd_vld = cav; ca_upd_val = cad;
    cnt_wr_vld = cwv; cnt_wr_val = cwd; sw_wr_en = sw; sw_wr_data = swd; mvcr_req = mv;
    if (mv) m_cond = {m_so, m_ov, m_ca, 1'b0};
    if (sw) begin
      m_so = swd[31]; m_ov = swd[30]; m_ca = swd[29];
    end else if (mv) begin
      m_so = 0; m_ov = 0; m_ca = 0;
    end else begin
      if (ovv) begin m_ov = ovd; m_so = m_so | ovd; end
      if (cav) m_ca = cad;
    end
    if (sw)       m_tbc = swd[6:0];
    else if (cwv) m_tbc = cwd;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    rst = 1'b1;
    {ov_upd_vld, ov_upd_val, ca_upd_vld, ca_upd_val, cnt_wr_vld, sw_wr_en, mvcr_req} = '0;
    cnt_wr_val = '0; sw_wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_so = 0; m_ov = 0; m_ca = 0; m_tbc = 0; m_cond = 0;
    check("R11 reset");

    // R1/R9: software write with reserved bits set; reserved must read zero
    cycle(0,0,0,0, 0,0, 1,32'hFFFF_FFFF, 0, "R1 R9 all-ones write");
    // R6/R7: move captures 1110 and clears flags, count kept
    cycle(0,0,0,0, 0,0, 0,0, 1, "R6 R7 move after write");
    // R5: overflow 1 sets OV and SO together
    cycle(1,1,0,0, 0,0, 0,0, 0, "R5 overflow set");
    // R2/R3: overflow 0 clears OV, SO stays
    cycle(1,0,0,0, 0,0, 0,0, 0, "R2 R3 overflow clear keeps SO");
    // R4: carry set then clear
    cycle(0,0,1,1, 0,0, 0,0, 0, "R4 carry set");
    cycle(0,0,1,0, 0,0, 0,0, 0, "R4 carry clear");
    // R8: byte count write
    cycle(0,0,0,0, 1,7'h15, 0,0, 0, "R8 count write");
    // R7: move with SO only set captures 1000
    cycle(0,0,0,0, 0,0, 0,0, 1, "R7 move capture SO");
    // R10: move beats exec updates
    cycle(1,1,1,1, 0,0, 0,0, 1, "R10 move over updates");
    // R9: software write beats exec, count and move
    cycle(1,1,1,1, 1,7'h7F, 1,32'h2000_0003, 1, "R9 sw over everything");
    // R2: SO only cleared by write/move, not by idle
    cycle(1,1,0,0, 0,0, 0,0, 0, "R2 set SO");
    cycle(0,0,0,0, 0,0, 0,0, 0, "R2 idle hold");

    for (int i = 0; i < 3000; i++) begin
      bit [31:0] r;
      r = $urandom;
      cycle(r[0], r[1], r[2], r[3], r[4], r[11:5],
            ($urandom % 8) == 0, $urandom, ($urandom % 6) == 0,
            "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule